// File: doc/BRIEF.md
# Urdhva-Style Tree Multiplier

An unsigned multiplier for two 8-bit operands that returns the full 16-bit product. It builds the product by splitting each operand in half again and again. At the bottom of the tree sit 2x2 multiplier cells, and all of them evaluate in the same combinational pass. Each level above joins four half-width sub-products: the two cross products are summed first, and that sum is then added to the concatenated outer products, shifted by half the width. A two-level carry-lookahead adder does every join.

The operand width is a parameter and must be a power of two of at least 2. With the same recursion, 16 selects a 16x16 multiplier built from 8x8 nodes. A second parameter puts a register after the tree. With the default setting the product appears one rising clock edge after the operands are sampled. With the register off, the block is purely combinational.

Top module: `urdhva_mul`

## Requirements
- R1: With the output register enabled, p_o after a rising edge of clk_i equals the unsigned product of the a_i and b_i sampled at that edge, for every one of the 65,536 operand pairs.
- R2: While rst_ni is low, p_o is 0. The clear takes effect at once and does not wait for a clock edge.
- R3: If either operand is 0, the product is 0, whatever the other operand is.
- R4: Operands 0xFF and 0xFF give 0xFE01. Carries propagate through every level of the tree.
- R5: If both operands are below 4, so only the lowest 2x2 cell contributes, the product matches the 2x2 table (for example 3x3 = 9, 2x3 = 6).
- R6: Operands that use only bits 7:4 give their nibble product placed at bit 8: (x<<4)*(y<<4) = (x*y)<<8.
- R7: If the two cross sub-products of a level are large enough that their sum carries, the result stays exact. Swapping the operands gives the same product.
- R8: A change on a_i or b_i between rising edges leaves p_o unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | WIDTH (8) | Unsigned multiplicand |
| b_i | input | WIDTH (8) | Unsigned multiplier |
| p_o | output | 2*WIDTH (16) | Unsigned product |

## Verification
Every operand pair is applied once, so a wrong bit anywhere in the tree cannot escape. Directed patterns then isolate parts of the tree. Small operands reach only the 2x2 cell at bit 0. Upper-nibble operands reach only the high-high branch and its alignment at bit 8. Cross-heavy pairs and the all-ones pair stress the middle-sum carry and the final adder. Zero operands confirm that no carry leaks from any level. Seeded random pairs are mixed with mid-cycle input changes and a mid-cycle reset, which separate the register's edge timing and asynchronous clear from the combinational result.

// File: rtl/umul_pkg.sv
package umul_pkg;
  localparam int unsigned CELL_W = 2;   // width of the leaf multiplier
  localparam int unsigned GRP_W  = 4;   // lookahead group size

  function automatic int unsigned prod_w(int unsigned w);
    return 2 * w;
  endfunction

  function automatic int unsigned grp_cnt(int unsigned w);
    return (w + GRP_W - 1) / GRP_W;
  endfunction
endpackage

// File: rtl/umul_cell2.sv
module umul_cell2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic t_lo, t_x0, t_x1, t_hi, c_mid;

  always_comb begin
    t_lo   = a_i[0] & b_i[0];
    t_x0   = a_i[1] & b_i[0];
    t_x1   = a_i[0] & b_i[1];
    t_hi   = a_i[1] & b_i[1];
    c_mid  = t_x0 & t_x1;
    p_o[0] = t_lo;
    p_o[1] = t_x0 ^ t_x1;
    p_o[2] = t_hi ^ c_mid;
    p_o[3] = t_hi & c_mid;
  end
endmodule

// File: rtl/umul_cla.sv
// Two-level carry lookahead: group generate/propagate, then bit carries from group carry-in.
module umul_cla #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned NG = umul_pkg::grp_cnt(W);
  localparam int unsigned WP = NG * umul_pkg::GRP_W;

  logic [WP-1:0] a_x, b_x, g, p, c, s;
  logic [NG-1:0] gg, gp, gc;

  assign a_x = WP'(a_i);
  assign b_x = WP'(b_i);
  assign g   = a_x & b_x;
  assign p   = a_x ^ b_x;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int unsigned B = 4 * k;
    assign gg[k] = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                 | (p[B+3] & p[B+2] & p[B+1] & g[B]);
    assign gp[k] = &p[B+3:B];
    if (k == 0) begin : g_c0
      assign gc[k] = 1'b0;
    end else begin : g_cn
      assign gc[k] = gg[k-1] | (gp[k-1] & gc[k-1]);
    end
    assign c[B]   = gc[k];
    assign c[B+1] = g[B] | (p[B] & gc[k]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & gc[k]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                  | (p[B+2] & p[B+1] & p[B] & gc[k]);
  end

  assign s   = p ^ c;
  assign s_o = s[W-1:0];
endmodule

// File: rtl/umul_merge.sv
// Joins four H x H sub-products into one 2H x 2H product.
module umul_merge #(
  parameter int unsigned H = 2
) (
  input  logic [2*H-1:0] ll_i,
  input  logic [2*H-1:0] hl_i,
  input  logic [2*H-1:0] lh_i,
  input  logic [2*H-1:0] hh_i,
  output logic [4*H-1:0] p_o
);
  localparam int unsigned PW = 4 * H;

  logic [PW-1:0] mid, mid_sh, outer;

  // cross terms first; width PW so the carry is kept
  umul_cla #(.W(PW)) u_mid (
    .a_i (PW'(hl_i)),
    .b_i (PW'(lh_i)),
    .s_o (mid)
  );

  assign mid_sh = mid << H;
  assign outer  = {hh_i, ll_i};

  umul_cla #(.W(PW)) u_fin (
    .a_i (outer),
    .b_i (mid_sh),
    .s_o (p_o)
  );
endmodule

// File: rtl/umul_node.sv
module umul_node #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H = W / 2;

  if (W == umul_pkg::CELL_W) begin : g_leaf
    umul_cell2 u_cell (
      .a_i (a_i),
      .b_i (b_i),
      .p_o (p_o)
    );
  end else begin : g_split
    logic [W-1:0] p_ll, p_hl, p_lh, p_hh;

    umul_node #(.W(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(p_ll));
    umul_node #(.W(H)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(p_hl));
    umul_node #(.W(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(p_lh));
    umul_node #(.W(H)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(p_hh));

    umul_merge #(.H(H)) u_merge (
      .ll_i (p_ll),
      .hl_i (p_hl),
      .lh_i (p_lh),
      .hh_i (p_hh),
      .p_o  (p_o)
    );
  end
endmodule

// File: rtl/urdhva_mul.sv
module urdhva_mul #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WIDTH-1:0]       a_i,
  input  logic [WIDTH-1:0]       b_i,
  output logic [2*WIDTH-1:0]     p_o
);
  localparam int unsigned PW = umul_pkg::prod_w(WIDTH);

  logic [PW-1:0] prod;

  umul_node #(.W(WIDTH)) u_tree (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (prod)
  );

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q <= '0;
      else         prod_q <= prod;
    end
    assign p_o = prod_q;
  end else begin : g_comb
    assign p_o = rst_ni ? prod : '0;
  end
endmodule

// File: rtl/urdhva_mul_chk.sv
module urdhva_mul_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WIDTH-1:0]     a_i,
  input logic [WIDTH-1:0]     b_i,
  input logic [2*WIDTH-1:0]   p_o
);
  localparam int unsigned PW = 2 * WIDTH;
  localparam logic [PW-1:0] AMAX = PW'((64'd1 << WIDTH) - 64'd1);
  localparam logic [PW-1:0] PMAX = AMAX * AMAX;

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2: cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) a_r2_reset_clear: assert (p_o == '0);
  end

  // R4: never above the largest product
  a_r4_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_o <= PMAX);

  if (REG_OUT) begin : g_seq
    a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> p_o == PW'($past(a_i)) * PW'($past(b_i)));

    a_r3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && ($past(a_i) == '0 || $past(b_i) == '0)) |-> p_o == '0);

    a_r5_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> p_o[0] == ($past(a_i[0]) & $past(b_i[0])));
  end else begin : g_cmb
    always @(posedge clk_i) begin
      if (rst_ni) begin
        a_r1_product: assert (p_o == PW'(a_i) * PW'(b_i));
        if (a_i == '0 || b_i == '0) a_r3_zero: assert (p_o == '0);
      end
    end
  end
endmodule

bind urdhva_mul urdhva_mul_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/urdhva_mul_test.sv
`timescale 1ns/1ps
module urdhva_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic [15:0] p;
  int unsigned n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  urdhva_mul uut (.clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .p_o(p));

  function automatic logic [15:0] ref_mul(logic [7:0] x, logic [7:0] y);
    return 16'(x) * 16'(y);
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the capturing edge
  task automatic apply(string req, logic [7:0] x, logic [7:0] y);
    @(negedge clk);
    a = x; b = y;
    @(posedge clk);
    #1;
    check(req, p, ref_mul(x, y));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    a = 8'hFF; b = 8'hFF;
    repeat (3) @(posedge clk);
    #1 check("R2 held reset", p, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    // R5: leaf cell only
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        apply("R5 2x2 cell", 8'(i), 8'(j));
    apply("R5 3x3", 8'd3, 8'd3);
    check("R5 3x3 value", p, 16'd9);

    // R3: zero operands
    apply("R3 a zero", 8'h00, 8'hFF);
    check("R3 a zero value", p, 16'h0000);
    apply("R3 b zero", 8'hA7, 8'h00);

    // R4: all ones
    apply("R4 all ones", 8'hFF, 8'hFF);
    check("R4 all ones value", p, 16'hFE01);

    // R6: upper nibbles only
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        apply("R6 upper nibble", 8'(i << 4), 8'(j << 4));
        check("R6 alignment", p, 16'((i * j) << 8));
      end

    // R7: heavy cross terms and operand swap
    apply("R7 cross", 8'hF0, 8'h0F);
    check("R7 cross value", p, 16'h0E10);
    apply("R7 cross carry", 8'hEF, 8'hFE);
    begin
      logic [15:0] fwd;
      fwd = p;
      apply("R7 swap", 8'hFE, 8'hEF);
      check("R7 swap equal", p, fwd);
    end

    // R8: mid-cycle operand change must not reach p_o
    apply("R8 setup", 8'h12, 8'h34);
    #0.5 a = 8'h99; b = 8'h77;
    #0.5 check("R8 hold", p, ref_mul(8'h12, 8'h34));
    @(posedge clk); #1 check("R8 update", p, ref_mul(8'h99, 8'h77));

    // R1: every pair
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply("R1 exhaustive", 8'(i), 8'(j));

    // R1: seeded random pairs
    for (int k = 0; k < 2000; k++)
      apply("R1 random", 8'($urandom), 8'($urandom));

    // R2: asynchronous clear mid-cycle
    apply("R2 pre", 8'hC3, 8'h5A);
    #0.7 rst_n = 1'b0;
    #0.3 check("R2 async clear", p, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    apply("R2 after release", 8'h81, 8'h81);

    finish_run();
  end
endmodule